// File: doc/BRIEF.md
# Dual-Channel Receiver Configuration Latch File

This block is the control register file for a two-channel serial receiver. A host writes 7-bit words through a narrow parallel port: a 3-bit address, a 7-bit data bus and an active-low write strobe. Each channel owns three write-only banks. Two banks hold setup values that rarely change, and the third holds enables that change at run time. The block decodes the stored bits into named control lines for the receive PLL, the reclocker drivers, the framer and decoder, the built-in pattern checker and the receive path. It also derives a per-channel logic power-down and two gated enables from those bits.

Nothing can be read back. Two addresses inside the map are reserved for test and have no effect. Bit positions that carry no function are not stored. A synchronous active-low reset returns every stored field to its preset. The preset leaves the PLL off, both reclocker drivers off and pattern checking disabled on both channels.

Top module: `rxcfg_latch_file`

## Requirements
- R1: On a rising clock edge with `cfg_wr_n` low and reset inactive, `cfg_data` is stored into the bank chosen by `cfg_addr`, and the new value appears on the outputs directly after that edge. Holding `cfg_wr_n` low for several edges with the same address and data leaves the outputs unchanged after the first of those edges.
- R2: On an edge with `cfg_wr_n` high, no output changes, whatever `cfg_addr` and `cfg_data` are.
- R3: Address map. Channel A (index 0) uses addresses 0, 1 and 2, and channel B (index 1) uses addresses 5, 6 and 7, in the order static-0, static-1, dynamic. Static-0 holds bit0 PLL enable, bits 2:1 rate select and bit3 framer enable, and bit4 holds the decoder enable. Static-1 holds bit0 reclock driver 1 enable and bit1 reclock driver 2 enable, and bits 3:2 hold the output swing. Dynamic holds bit0 BIST enable, bit1 receive enable and bit2 lock reference select. Each 2-bit field of channel c sits at bits [2c+1:2c] of its output port.
- R4: A write to address 3 or 4 changes no output.
- R5: After reset, static-0 reads as 0x10 (decoder enabled, all else off), static-1 reads as 0x04 (output swing 01, drivers off) and dynamic reads as 0x00 on both channels.
- R6: After reset, `bist_en` is 0 on both channels.
- R7: `chan_logic_pd[c]` is 1 exactly when both reclock driver enables of channel c are 0. `reclk_active[c]` is 1 only when the PLL enable is 1 and the channel logic is not powered down.
- R8: `deser_en[c]` equals PLL enable AND receive enable of channel c, and does not depend on the reclock driver enables.
- R9: When reset is asserted on the same edge as a write, reset wins and every field takes its preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_n | input | 1 | Active-low write strobe |
| cfg_addr | input | 3 | Bank address |
| cfg_data | input | 7 | Write data |
| rx_pll_en | output | 2 | Receive PLL and analog enable per channel |
| rate_sel | output | 4 | Rate select, 2 bits per channel |
| framer_en | output | 2 | Framer enable per channel |
| decoder_en | output | 2 | Decoder enable per channel |
| rclk_out1_en | output | 2 | Reclock serial driver 1 enable |
| rclk_out2_en | output | 2 | Reclock serial driver 2 enable |
| out_swing | output | 4 | Driver swing, 2 bits per channel |
| bist_en | output | 2 | Pattern checker enable |
| rx_en | output | 2 | Receive path enable |
| lock_ref_sel | output | 2 | PLL lock reference select |
| chan_logic_pd | output | 2 | Channel reclock logic power-down |
| reclk_active | output | 2 | Reclocker running |
| deser_en | output | 2 | Deserializer and parallel output enable |

## Verification
A reset and a write can land on the same edge, and only one of them may win. The bench drives `rst_n` low on an edge while `cfg_wr_n` is low with all-ones data at a mapped address. A reference model that applies reset first must then match every output on the following cycle. A second overlap comes from a static-1 write that powers down the channel logic while the dynamic bank has the receive path enabled. The bench then judges `deser_en` unchanged in the same cycle that `reclk_active` falls.

// File: rtl/rxcfg_pkg.sv
// Shared constants and types for the receiver configuration latch file.
// Assumes two channels, three banks per channel, and a channel stride of five addresses.
package rxcfg_pkg;
    localparam int DATA_W       = 7;
    localparam int ADDR_W       = 3;
    localparam int NUM_CH       = 2;
    localparam int BANKS_PER_CH = 3;
    localparam int CH_STRIDE    = 5;
    localparam int NUM_BANKS    = NUM_CH * BANKS_PER_CH;

    // Bank roles inside one channel
    localparam int BK_STAT0 = 0;
    localparam int BK_STAT1 = 1;
    localparam int BK_DYN   = 2;

    // Stored-bit masks and reset presets per bank role
    localparam logic [DATA_W-1:0] KEEP_STAT0   = 7'b001_1111;
    localparam logic [DATA_W-1:0] KEEP_STAT1   = 7'b000_1111;
    localparam logic [DATA_W-1:0] KEEP_DYN     = 7'b000_0111;
    localparam logic [DATA_W-1:0] PRESET_STAT0 = 7'h10;
    localparam logic [DATA_W-1:0] PRESET_STAT1 = 7'h04;
    localparam logic [DATA_W-1:0] PRESET_DYN   = 7'h00;

    // Decoded per-channel control fields
    typedef struct packed {
        logic       pll_en;
        logic [1:0] rate_sel;
        logic       framer_en;
        logic       decoder_en;
        logic       rclk_out1_en;
        logic       rclk_out2_en;
        logic [1:0] out_swing;
        logic       bist_en;
        logic       rx_en;
        logic       lock_ref_sel;
        logic       logic_pd;
        logic       reclk_active;
        logic       deser_en;
    } chan_ctl_t;

    function automatic logic [DATA_W-1:0] keep_of(input int role);
        case (role)
            BK_STAT0: keep_of = KEEP_STAT0;
            BK_STAT1: keep_of = KEEP_STAT1;
            default:  keep_of = KEEP_DYN;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] preset_of(input int role);
        case (role)
            BK_STAT0: preset_of = PRESET_STAT0;
            BK_STAT1: preset_of = PRESET_STAT1;
            default:  preset_of = PRESET_DYN;
        endcase
    endfunction
endpackage

// File: rtl/rxcfg_addr_decode.sv
// Address decoder: turns the address and write strobe into one write-select per bank.
// Assumes bank b of channel c lives at address c*CH_STRIDE+b. Addresses outside the map select nothing.
module rxcfg_addr_decode
    import rxcfg_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int NCH     = NUM_CH,
    parameter int NBK     = BANKS_PER_CH,
    parameter int STRIDE  = CH_STRIDE,
    localparam int NSEL   = NCH * NBK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    output logic [NSEL-1:0] wr_sel
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        for (genvar b = 0; b < NBK; b++) begin : g_bk
            localparam int BANK_ADDR = c * STRIDE + b;
            // Purpose: raise the select of this bank when it is addressed during a write
            always_comb wr_sel[c*NBK+b] = !wr_n && (addr == AW'(BANK_ADDR));
        end
    end

    // R3
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R4
    test_addr_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == AW'(3) || addr == AW'(4)) |-> (wr_sel == '0));
endmodule

// File: rtl/rxcfg_bank.sv
// One write-only configuration bank with a synchronous preset.
// Assumes only the bits set in KEEP carry a function. The other bits are not stored and read as 0.
module rxcfg_bank #(
    parameter int          W      = 7,
    parameter logic [W-1:0] KEEP   = '1,
    parameter logic [W-1:0] PRESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic unused_dbits;
    assign unused_dbits = ^(d & ~KEEP);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (KEEP[i]) begin : g_store
            // Purpose: hold one functional bit, preset on reset, load on write
            always_ff @(posedge clk) begin
                if (!rst_n)  q[i] <= PRESET[i];
                else if (we) q[i] <= d[i];
            end
        end else begin : g_void
            assign q[i] = 1'b0;
        end
    end

    // R1
    bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == ($past(d) & KEEP)));

    // R2
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/rxcfg_chan_ctrl.sv
// Channel control decode: splits a channel's three banks into named fields and derives power controls.
// Assumes the bank words are already masked, so unused bits are 0.
module rxcfg_chan_ctrl
    import rxcfg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] stat0,
    input  logic [W-1:0] stat1,
    input  logic [W-1:0] dyn,
    output chan_ctl_t    ctl
);
    logic unused_spare;
    assign unused_spare = ^{stat0[W-1:5], stat1[W-1:4], dyn[W-1:3]};

    // Purpose: map the stored bits to fields and form the derived enables
    always_comb begin
        ctl              = '0;
        ctl.pll_en       = stat0[0];
        ctl.rate_sel     = stat0[2:1];
        ctl.framer_en    = stat0[3];
        ctl.decoder_en   = stat0[4];
        ctl.rclk_out1_en = stat1[0];
        ctl.rclk_out2_en = stat1[1];
        ctl.out_swing    = stat1[3:2];
        ctl.bist_en      = dyn[0];
        ctl.rx_en        = dyn[1];
        ctl.lock_ref_sel = dyn[2];
        ctl.logic_pd     = !(stat1[0] || stat1[1]);
        ctl.reclk_active = stat0[0] && (stat1[0] || stat1[1]);
        ctl.deser_en     = stat0[0] && dyn[1];
    end
endmodule

// File: rtl/rxcfg_latch_file.sv
// Top of the configuration latch file: decoder, per-channel banks and channel decode.
// Assumes a synchronous active-low reset and writes sampled on the rising clock edge.
module rxcfg_latch_file
    import rxcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_n,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    output logic [NUM_CH-1:0]   rx_pll_en,
    output logic [2*NUM_CH-1:0] rate_sel,
    output logic [NUM_CH-1:0]   framer_en,
    output logic [NUM_CH-1:0]   decoder_en,
    output logic [NUM_CH-1:0]   rclk_out1_en,
    output logic [NUM_CH-1:0]   rclk_out2_en,
    output logic [2*NUM_CH-1:0] out_swing,
    output logic [NUM_CH-1:0]   bist_en,
    output logic [NUM_CH-1:0]   rx_en,
    output logic [NUM_CH-1:0]   lock_ref_sel,
    output logic [NUM_CH-1:0]   chan_logic_pd,
    output logic [NUM_CH-1:0]   reclk_active,
    output logic [NUM_CH-1:0]   deser_en
);
    logic [NUM_BANKS-1:0]  wr_sel;
    logic [DATA_W-1:0]     bank_q [NUM_BANKS];
    chan_ctl_t             ctl    [NUM_CH];

    rxcfg_addr_decode #(
        .AW(ADDR_W), .NCH(NUM_CH), .NBK(BANKS_PER_CH), .STRIDE(CH_STRIDE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .wr_n(cfg_wr_n), .addr(cfg_addr), .wr_sel(wr_sel)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        for (genvar b = 0; b < BANKS_PER_CH; b++) begin : g_bk
            rxcfg_bank #(
                .W(DATA_W), .KEEP(keep_of(b)), .PRESET(preset_of(b))
            ) u_bank (
                .clk(clk), .rst_n(rst_n), .we(wr_sel[c*BANKS_PER_CH+b]),
                .d(cfg_data), .q(bank_q[c*BANKS_PER_CH+b])
            );
        end

        rxcfg_chan_ctrl #(.W(DATA_W)) u_ctl (
            .stat0(bank_q[c*BANKS_PER_CH+BK_STAT0]),
            .stat1(bank_q[c*BANKS_PER_CH+BK_STAT1]),
            .dyn  (bank_q[c*BANKS_PER_CH+BK_DYN]),
            .ctl  (ctl[c])
        );

        // Purpose: spread the channel fields onto the flat output ports
        always_comb begin
            rx_pll_en[c]          = ctl[c].pll_en;
            rate_sel[2*c +: 2]    = ctl[c].rate_sel;
            framer_en[c]          = ctl[c].framer_en;
            decoder_en[c]         = ctl[c].decoder_en;
            rclk_out1_en[c]       = ctl[c].rclk_out1_en;
            rclk_out2_en[c]       = ctl[c].rclk_out2_en;
            out_swing[2*c +: 2]   = ctl[c].out_swing;
            bist_en[c]            = ctl[c].bist_en;
            rx_en[c]              = ctl[c].rx_en;
            lock_ref_sel[c]       = ctl[c].lock_ref_sel;
            chan_logic_pd[c]      = ctl[c].logic_pd;
            reclk_active[c]       = ctl[c].reclk_active;
            deser_en[c]           = ctl[c].deser_en;
        end

        // R7
        pd_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(chan_logic_pd[c]) && $past(rst_n)) |-> $past(!cfg_wr_n));
    end

    // R6
    bist_off_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (bist_en == '0));

    // R9
    preset_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (rx_pll_en == '0 && decoder_en == '1 && rx_en == '0
                           && chan_logic_pd == '1));

    // R4
    test_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_wr_n && (cfg_addr == 3'd3 || cfg_addr == 3'd4))
            |=> $stable({rx_pll_en, rate_sel, framer_en, decoder_en, rclk_out1_en,
                         rclk_out2_en, out_swing, bist_en, rx_en, lock_ref_sel}));
endmodule

// File: tb/rxcfg_latch_file_test.sv
module rxcfg_latch_file_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_n = 1'b1;
    logic [2:0] cfg_addr = 3'd0;
    logic [6:0] cfg_data = 7'd0;
    logic [1:0] rx_pll_en, framer_en, decoder_en, rclk_out1_en, rclk_out2_en;
    logic [1:0] bist_en, rx_en, lock_ref_sel, chan_logic_pd, reclk_active, deser_en;
    logic [3:0] rate_sel, out_swing;

    int    vectors = 0;
    int    fails   = 0;
    bit    armed   = 0;
    bit    done    = 0;
    string cur_req = "R5";
    logic [6:0] mb [8];

    always #5 clk = ~clk;

    rxcfg_latch_file uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_n(cfg_wr_n), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .rx_pll_en(rx_pll_en), .rate_sel(rate_sel),
        .framer_en(framer_en), .decoder_en(decoder_en), .rclk_out1_en(rclk_out1_en),
        .rclk_out2_en(rclk_out2_en), .out_swing(out_swing), .bist_en(bist_en),
        .rx_en(rx_en), .lock_ref_sel(lock_ref_sel), .chan_logic_pd(chan_logic_pd),
        .reclk_active(reclk_active), .deser_en(deser_en)
    );

    function automatic logic [6:0] keep_for(int a);
        case (a % 5)
            0: return 7'h1F;
            1: return 7'h0F;
            default: return 7'h07;
        endcase
    endfunction

    function automatic logic [6:0] preset_for(int a);
        case (a % 5)
            0: return 7'h10;
            1: return 7'h04;
            default: return 7'h00;
        endcase
    endfunction

    // Reference model: updated on each rising edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 8; a++) mb[a] = preset_for(a);
        end else if (!cfg_wr_n && cfg_addr != 3'd3 && cfg_addr != 3'd4) begin
            mb[cfg_addr] = cfg_data & keep_for(int'(cfg_addr));
        end
        armed = 1;
    end

    function automatic logic [29:0] expected();
        logic [1:0] pll, fr, dc, o1, o2, be, re, ls, pd, ra, de;
        logic [3:0] rs, sw;
        for (int c = 0; c < 2; c++) begin
            logic [6:0] s0, s1, dy;
            s0 = mb[c*5]; s1 = mb[c*5+1]; dy = mb[c*5+2];
            pll[c] = s0[0]; rs[2*c+:2] = s0[2:1]; fr[c] = s0[3]; dc[c] = s0[4];
            o1[c] = s1[0]; o2[c] = s1[1]; sw[2*c+:2] = s1[3:2];
            be[c] = dy[0]; re[c] = dy[1]; ls[c] = dy[2];
            pd[c] = (s1[1:0] == 2'b00);
            ra[c] = s0[0] && !pd[c];
            de[c] = s0[0] && dy[1];
        end
        return {pll, rs, fr, dc, o1, o2, sw, be, re, ls, pd, ra, de};
    endfunction

    // Compare on every falling edge, away from the active edge
    always @(negedge clk) begin
        logic [29:0] act, exp_v;
        if (armed && !done) begin
            act = {rx_pll_en, rate_sel, framer_en, decoder_en, rclk_out1_en, rclk_out2_en,
                   out_swing, bist_en, rx_en, lock_ref_sel, chan_logic_pd, reclk_active, deser_en};
            exp_v = expected();
            vectors++;
            if (act !== exp_v) begin
                fails++;
                $display("FAIL %s: outputs %h expected %h", cur_req, act, exp_v);
            end
        end
    end

    task automatic step(input logic wn, input logic [2:0] a, input logic [6:0] d);
        @(negedge clk);
        #1;
        cfg_wr_n = wn; cfg_addr = a; cfg_data = d;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run incomplete, expected finish");
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R5, R6: reset presets
        cur_req = "R5/R6";
        repeat (3) step(1'b1, 3'd0, 7'h00);
        rst_n = 1'b1;
        repeat (2) step(1'b1, 3'd0, 7'h00);

        // R2: strobe high with changing address and data
        cur_req = "R2";
        for (int a = 0; a < 8; a++) step(1'b1, 3'(a), 7'h7F);

        // R3: every mapped address, all ones then a pattern
        cur_req = "R3";
        foreach (mb[a]) if (a != 3 && a != 4) step(1'b0, 3'(a), 7'h7F);
        step(1'b1, 3'd0, 7'h00);
        foreach (mb[a]) if (a != 3 && a != 4) step(1'b0, 3'(a), 7'(7'h55 ^ a));
        step(1'b1, 3'd0, 7'h00);

        // R4: test addresses
        cur_req = "R4";
        step(1'b0, 3'd3, 7'h7F);
        step(1'b0, 3'd4, 7'h00);
        step(1'b0, 3'd3, 7'h2A);
        step(1'b1, 3'd4, 7'h00);

        // R8: receive path on, then drivers switched, deserializer unaffected
        cur_req = "R8";
        step(1'b0, 3'd0, 7'h01);
        step(1'b0, 3'd2, 7'h02);
        step(1'b0, 3'd1, 7'h03);
        step(1'b0, 3'd1, 7'h00);
        step(1'b1, 3'd0, 7'h00);

        // R7: each single driver on, then both off, both channels
        cur_req = "R7";
        step(1'b0, 3'd1, 7'h01);
        step(1'b0, 3'd1, 7'h02);
        step(1'b0, 3'd6, 7'h02);
        step(1'b0, 3'd5, 7'h01);
        step(1'b0, 3'd6, 7'h00);
        step(1'b0, 3'd1, 7'h00);
        step(1'b1, 3'd0, 7'h00);

        // R1: hold the strobe low with the same word
        cur_req = "R1";
        repeat (4) step(1'b0, 3'd7, 7'h05);
        step(1'b1, 3'd7, 7'h00);

        // R9: reset collides with a write
        cur_req = "R9";
        step(1'b0, 3'd0, 7'h7F);
        rst_n = 1'b0;
        step(1'b0, 3'd2, 7'h7F);
        rst_n = 1'b1;
        step(1'b1, 3'd0, 7'h00);
        step(1'b1, 3'd0, 7'h00);

        // R6: BIST back off after the collision reset
        cur_req = "R6";
        step(1'b1, 3'd2, 7'h01);

        // R1: mixed traffic
        cur_req = "R1";
        for (int i = 0; i < 3000; i++)
            step(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), 7'($urandom));
        step(1'b1, 3'd0, 7'h00);
        step(1'b1, 3'd0, 7'h00);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule